// File: doc/BRIEF.md
# Replicated-Storage Multi-Read Register File

This block is a register file with a single write port and a parameterised number of independent read ports. It has no true multi-ported array. Storage is made of several identical two-port synchronous RAM copies, each with registered inputs and a registered output, and every copy holds the same contents. Each copy has two sides. The shared side carries the write: its address mux picks the write address whenever the write enable is high, and otherwise picks its own read address. The free side serves a second read address on every cycle. For read port `p`, the copy is `p/2`. An even `p` sits on the copy's shared side and an odd `p` sits on its free side. With an odd port count, the free side of the last copy is left unused.

Each write is sent to all copies in the same cycle. A read address is sampled on a rising clock edge, and the matching data is driven on the following cycle. Inside a single copy, a read on the free side of the location being written on the shared side would return stale contents. A forwarding stage next to each free side therefore returns the incoming word in that case. A read in a given cycle therefore cannot return the value that the same cycle's write overwrites.

Top module: `regfile_multiread`

## Requirements
- R1: While `rst` is high, every read data output is zero from the first rising edge onward.
- R2: Data for an address sampled on a rising edge appears on that port after the edge and is held until the next edge.
- R3: Free-side ports (odd index) that sample the same address on the same edge return the same data. Shared-side ports (even index) do the same in cycles without a write.
- R4: A write with `wr_en` high updates all copies. A later read of that address on any port returns the written word.
- R5: A free-side port (odd index) that reads the address being written on the same edge returns the new word, not the old contents.
- R6: In a cycle with `wr_en` high, every shared-side port (even index) returns the write data, whatever its own read address.
- R7: With no write in either of two consecutive cycles, a port holding its address keeps its read data unchanged.
- R8: While `wr_en` is low, changes on `wr_addr` and `wr_data` leave every location unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the read output registers |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write location |
| wr_data | input | DATA_W | Write word |
| rd_addr | input | NUM_RD x ADDR_W | Per-port read location, port p in slice p |
| rd_data | output | NUM_RD x DATA_W | Per-port read word, one cycle after its address |

## Verification
The assertions assume that inputs are free of unknowns at every rising edge and that reset is held for at least two edges. The hold-stability property applies only to cycles in which the two previous edges both saw `wr_en` low, so it relies on the write strobe being the only path that changes storage. The stimulus is driven on falling edges and holds reset for several cycles. It fills every location before any read of it is checked. Checks on shared-side ports during writes are limited to the write-data behaviour.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    typedef enum logic {
        SIDE_SHARED = 1'b0,
        SIDE_FREE   = 1'b1
    } side_e;

    function automatic int copies_for(input int nports);
        return (nports + 1) / 2;
    endfunction

    function automatic int copy_of(input int port);
        return port / 2;
    endfunction

    function automatic side_e side_of(input int port);
        return ((port % 2) != 0) ? SIDE_FREE : SIDE_SHARED;
    endfunction

    function automatic bit copy_has_free(input int copy, input int nports);
        return (2 * copy + 1) < nports;
    endfunction

endpackage

// File: rtl/rf_dp_ram.sv
module rf_dp_ram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter bit HAS_B  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_din,
    output logic [DATA_W-1:0] a_dout,
    input  logic [ADDR_W-1:0] b_addr,
    output logic [DATA_W-1:0] b_dout
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Array update on the edge; reads below see pre-edge contents.
    always_ff @(posedge clk) begin
        if (a_we) begin
            mem[a_addr] <= a_din;
        end
    end

    // Side A output register, write-through on its own write.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_dout <= '0;
        end else begin
            a_dout <= a_we ? a_din : mem[a_addr];
        end
    end

    generate
        if (HAS_B) begin : g_side_b
            always_ff @(posedge clk) begin
                if (rst) begin
                    b_dout <= '0;
                end else begin
                    b_dout <= mem[b_addr];
                end
            end
        end else begin : g_no_side_b
            logic unused_b;
            assign unused_b = ^b_addr;
            assign b_dout   = '0;
        end
    endgenerate

endmodule

// File: rtl/rf_fwd.sv
module rf_fwd #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] ram_q,
    output logic [DATA_W-1:0] rd_q
);
    typedef struct packed {
        logic              hit;
        logic [DATA_W-1:0] word;
    } fwd_t;

    fwd_t fwd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_q <= '0;
        end else begin
            fwd_q.hit  <= wr_en && (wr_addr == rd_addr);
            fwd_q.word <= wr_data;
        end
    end

    assign rd_q = fwd_q.hit ? fwd_q.word : ram_q;

endmodule

// File: rtl/rf_copy.sv
module rf_copy #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter bit HAS_B  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] shr_addr,
    input  logic [ADDR_W-1:0] free_addr,
    output logic [DATA_W-1:0] shr_data,
    output logic [DATA_W-1:0] free_data
);
    logic [ADDR_W-1:0] a_addr_mux;
    logic [DATA_W-1:0] b_raw;

    // Write strobe selects the shared side's address source.
    assign a_addr_mux = wr_en ? wr_addr : shr_addr;

    rf_dp_ram #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .HAS_B  (HAS_B)
    ) u_ram (
        .clk    (clk),
        .rst    (rst),
        .a_we   (wr_en),
        .a_addr (a_addr_mux),
        .a_din  (wr_data),
        .a_dout (shr_data),
        .b_addr (free_addr),
        .b_dout (b_raw)
    );

    generate
        if (HAS_B) begin : g_fwd
            rf_fwd #(
                .DATA_W (DATA_W),
                .ADDR_W (ADDR_W)
            ) u_fwd (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (wr_en),
                .wr_addr (wr_addr),
                .wr_data (wr_data),
                .rd_addr (free_addr),
                .ram_q   (b_raw),
                .rd_q    (free_data)
            );
        end else begin : g_nofwd
            assign free_data = b_raw;
        end
    endgenerate

endmodule

// File: rtl/regfile_multiread.sv
module regfile_multiread
    import regfile_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int NUM_RD = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr,
    output logic [NUM_RD-1:0][DATA_W-1:0] rd_data
);
    localparam int NCOPY = copies_for(NUM_RD);

    generate
        for (genvar c = 0; c < NCOPY; c++) begin : g_copy
            localparam bit HB   = copy_has_free(c, NUM_RD);
            localparam int PSHR = 2 * c;
            localparam int PFRE = HB ? (2 * c + 1) : (2 * c);

            logic [DATA_W-1:0] free_q;

            rf_copy #(
                .DATA_W (DATA_W),
                .ADDR_W (ADDR_W),
                .HAS_B  (HB)
            ) u_copy (
                .clk       (clk),
                .rst       (rst),
                .wr_en     (wr_en),
                .wr_addr   (wr_addr),
                .wr_data   (wr_data),
                .shr_addr  (rd_addr[PSHR]),
                .free_addr (rd_addr[PFRE]),
                .shr_data  (rd_data[PSHR]),
                .free_data (free_q)
            );

            if (HB) begin : g_free_out
                assign rd_data[PFRE] = free_q;
            end else begin : g_free_drop
                logic unused_free;
                assign unused_free = ^free_q;
            end
        end
    endgenerate

endmodule

// File: rtl/regfile_multiread_chk.sv
module regfile_multiread_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int NUM_RD = 5
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [DATA_W-1:0]             wr_data,
    input logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr,
    input logic [NUM_RD-1:0][DATA_W-1:0] rd_data
);
    logic [1:0] live;
    logic       rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            live <= '0;
        end else if (live != 2'd3) begin
            live <= live + 2'd1;
        end
    end

    always @(posedge clk) begin
        if (rst && rst_q) begin
            assert_reset_zero_R1: assert (rd_data == '0)
                else $error("read data not cleared in reset");
        end
    end

    generate
        for (genvar p = 0; p < NUM_RD; p++) begin : g_port
            if ((p % 2) == 1) begin : g_free
                assert_bypass_R5: assert property (@(posedge clk) disable iff (rst)
                    (live != 0 && $past(wr_en) && $past(wr_addr) == $past(rd_addr[p]))
                    |-> rd_data[p] == $past(wr_data));
                if (p > 1) begin : g_agree
                    assert_copies_agree_R3: assert property (@(posedge clk) disable iff (rst)
                        (live != 0 && $past(rd_addr[p]) == $past(rd_addr[1]))
                        |-> rd_data[p] == rd_data[1]);
                end
            end else begin : g_shr
                assert_shared_write_R6: assert property (@(posedge clk) disable iff (rst)
                    (live != 0 && $past(wr_en)) |-> rd_data[p] == $past(wr_data));
            end
            assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
                (live >= 2 && !$past(wr_en) && !$past(wr_en, 2)
                 && $past(rd_addr[p]) == $past(rd_addr[p], 2))
                |-> $stable(rd_data[p]));
        end
    endgenerate

endmodule

bind regfile_multiread regfile_multiread_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NUM_RD (NUM_RD)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/tb_regfile_multiread.sv
`timescale 1ns/1ps
module tb_regfile_multiread;
    localparam int DW    = 16;
    localparam int AW    = 4;
    localparam int NR    = 5;
    localparam int DEPTH = 1 << AW;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  wr_en = 1'b0;
    logic [AW-1:0]         wr_addr = '0;
    logic [DW-1:0]         wr_data = '0;
    logic [NR-1:0][AW-1:0] rd_addr = '0;
    logic [NR-1:0][DW-1:0] rd_data;

    int n_vec  = 0;
    int n_fail = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    bit            ref_ok  [DEPTH];

    always #10 clk = ~clk;

    regfile_multiread #(.DATA_W(DW), .ADDR_W(AW), .NUM_RD(NR)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string tag, input int port,
                         input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s port %0d: got %h expected %h", tag, port, got, exp);
        end
    endtask

    // Called at a falling edge; applies inputs, waits one edge, checks.
    task automatic cycle(input logic we, input logic [AW-1:0] wa,
                         input logic [DW-1:0] wd,
                         input logic [NR-1:0][AW-1:0] ra, input string tag);
        logic [DW-1:0] exp [NR];
        bit            val [NR];
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        for (int p = 0; p < NR; p++) begin
            if ((p % 2) == 0 && we) begin
                exp[p] = wd; val[p] = 1'b1;
            end else if (we && wa == ra[p]) begin
                exp[p] = wd; val[p] = 1'b1;
            end else begin
                exp[p] = ref_mem[ra[p]]; val[p] = ref_ok[ra[p]];
            end
        end
        if (we) begin
            ref_mem[wa] = wd; ref_ok[wa] = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < NR; p++) begin
            if (val[p]) check(tag, p, rd_data[p], exp[p]);
        end
    endtask

    function automatic logic [NR-1:0][AW-1:0] spread(input int base);
        logic [NR-1:0][AW-1:0] r;
        for (int p = 0; p < NR; p++) r[p] = AW'(base + 3 * p);
        return r;
    endfunction

    function automatic logic [NR-1:0][AW-1:0] all_at(input int a);
        logic [NR-1:0][AW-1:0] r;
        for (int p = 0; p < NR; p++) r[p] = AW'(a);
        return r;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < NR; p++) check("R1", p, rd_data[p], '0);
        rst = 1'b0;
    endtask

    task automatic t_fill();
        for (int a = 0; a < DEPTH; a++)
            cycle(1'b1, AW'(a), DW'(16'h1000 + a * 16'h0111), spread(a), "R4");
        for (int a = 0; a < DEPTH; a++)
            cycle(1'b0, '0, '0, spread(a), "R2");
    endtask

    task automatic t_bypass();
        for (int a = 2; a < DEPTH; a += 5) begin
            cycle(1'b1, AW'(a), DW'(16'hB000 ^ a), all_at(a), "R5");
            cycle(1'b0, '0, '0, all_at(a), "R4");
        end
    endtask

    task automatic t_shared();
        for (int k = 0; k < 4; k++)
            cycle(1'b1, AW'(3), DW'(16'h5A00 + k), spread(k + 4), "R6");
    endtask

    task automatic t_same();
        for (int a = 0; a < DEPTH; a += 3)
            cycle(1'b0, '0, '0, all_at(a), "R3");
    endtask

    task automatic t_idle();
        for (int k = 0; k < 8; k++)
            cycle(1'b0, AW'(k), DW'(16'hDEAD + k), spread(k), "R8");
        for (int a = 0; a < DEPTH; a++)
            cycle(1'b0, '0, '0, all_at(a), "R8");
    endtask

    task automatic t_hold();
        for (int k = 0; k < 5; k++)
            cycle(1'b0, '0, '0, spread(7), "R7");
    endtask

    task automatic t_mixed();
        logic [15:0] lfsr = 16'hACE1;
        for (int k = 0; k < 300; k++) begin
            logic [NR-1:0][AW-1:0] ra;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            for (int p = 0; p < NR; p++) ra[p] = AW'(lfsr >> p);
            cycle(lfsr[0], AW'(lfsr[7:4]), lfsr ^ 16'h3C3C, ra, "R2");
        end
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) begin
            ref_mem[a] = '0; ref_ok[a] = 1'b0;
        end
        @(negedge clk);
        t_reset();
        t_fill();
        t_bypass();
        t_shared();
        t_same();
        t_idle();
        t_hold();
        t_mixed();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule